// File: doc/BRIEF.md
# Character Pattern Fetch Address Generator

This block sits beside a video shifter in a home-computer display path. On each display fetch the processor presents an opcode byte whose low six bits name a character and whose top bit asks for inverse video. During the refresh cycle that follows, the block captures the refresh address, the fetch program counter and the current scan line. From these it forms two addresses: one for the byte that holds the pixel pattern and one for the colour attribute byte. When the memory returns both bytes, the block applies inversion and colour policy and passes a finished pixel byte and attribute byte to the shifter.

Four fetch modes exist. They are selected by static switches and by the refresh address itself:
- The plain 64-character mode uses only a 512-byte pattern table.
- A 128-character mode takes a second half-table for inverse characters. It is enabled by bit 0 of the I register when the refresh address lies in the 8K add-on window.
- A fixed character-board region can be used instead.
- In raw-pixel mode the refresh address points straight at the pixel byte.

Colour can be off, taken per character line (mode 0), or taken per screen position (mode 1). While sync is active the output is forced black and no memory request is raised.

Top module: `patfetch_gen`

## Requirements
- R1: While rst_n is low at a clock edge, pat_addr, attr_addr, fetch_mode, pat_req, attr_req, pix_out, attr_out and out_valid all become zero.
- R2: With no other mode selected, a strobed fetch gives pat_addr = {ir_val[15:9], opcode[5:0], line_cnt[2:0]} and fetch_mode = 0. Bit 8 of ir_val is ignored.
- R3: When sw_board and sw_raw are low, sw_ram2000 is high and (ir_val & 0xE100) == 0x2100, fetch_mode = 1. pat_addr is the R2 address plus 0x200 when opcode[7] is set, and the R2 address otherwise.
- R4: When sw_board is high, whatever the other switches, fetch_mode = 2 and pat_addr = 0x8400 + {opcode[5:0], line_cnt} + (opcode[7] ? 0x200 : 0).
- R5: When sw_raw is high and sw_board is low, fetch_mode = 3 and pat_addr = ir_val if ir_val is in 0x2000..0x3FFF with sw_ram2000 high, or in 0x4000..0x7FFF with sw_ram4000 high. Otherwise the R2 path applies with fetch_mode = 0, even for addresses that would meet R3.
- R6: One clock after a cycle with rd_valid high, out_valid is high for exactly one cycle. pix_out is ~pat_data when the strobed opcode[7] was set, and pat_data otherwise.
- R7: attr_addr is 0xC000 + {opcode[5:0], line_cnt} when colour_mode is 0, or 0xC000 in raw-pixel mode. It is fetch_pc | 0xC000 when colour_mode is 1.
- R8: When colour_en was low at the strobe, attr_req is 0 and attr_out is 0x70 (white paper in bits 7:4, black pen in bits 3:0). When colour_en was high and sync was low, attr_req is 1 and attr_out equals attr_data.
- R9: When sync_active is high at the strobe, pat_req and attr_req are 0. The next output has pix_out = 0x00 and attr_out = 0x00, whatever the read data and the inversion flag.
- R10: Address, mode, request and flag outputs change only on a clock edge with fetch_strobe high, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_strobe | input | 1 | Refresh cycle: capture the fetch inputs and form addresses |
| opcode | input | 8 | Character code byte (bits 5:0 code, bit 7 invert) |
| fetch_pc | input | 16 | Program counter of the character fetch |
| ir_val | input | 16 | I and R register value on the bus during refresh |
| line_cnt | input | 3 | Scan line within the character row |
| sw_ram2000 | input | 1 | 8K add-on RAM at 0x2000 is fitted |
| sw_ram4000 | input | 1 | 16K add-on RAM at 0x4000 is fitted |
| sw_raw | input | 1 | Raw-pixel mode switch |
| sw_board | input | 1 | Fixed character-board region switch |
| colour_en | input | 1 | Colour output enabled |
| colour_mode | input | 1 | 0: attribute per pattern line, 1: attribute per screen address |
| sync_active | input | 1 | Video sync in progress |
| rd_valid | input | 1 | Pattern and attribute read data are valid |
| pat_data | input | 8 | Pattern byte read from pat_addr |
| attr_data | input | 8 | Attribute byte read from attr_addr |
| pat_addr | output | 16 | Pattern byte address |
| attr_addr | output | 16 | Attribute byte address |
| fetch_mode | output | 2 | 0 plain, 1 128-character, 2 board, 3 raw |
| pat_req | output | 1 | Pattern read wanted |
| attr_req | output | 1 | Attribute read wanted |
| pix_out | output | 8 | Final pixel byte to the shifter |
| attr_out | output | 8 | Final attribute byte to the shifter |
| out_valid | output | 1 | pix_out and attr_out are valid |

## Verification
A wrong mode decision shows up in pat_addr and fetch_mode in the cycle right after the strobe. Typical faults are a lost priority between board and raw, or a wrong mask or match on the 128-character test. They are exposed at once by refresh addresses chosen to sit on both sides of each window edge. A stale inversion or colour flag only shows in pix_out and attr_out one clock after the read strobe. For that reason every fetch is followed to its output, with the inversion and colour settings varied between fetches. A held sync or colour state that leaks from one fetch into the next would appear in the request bits of the following strobe.

// File: rtl/patfetch_pkg.sv
// Shared widths, constants and types for the pattern fetch generator.
// Assumes a 16-bit address space and an 8-bit data bus.
package patfetch_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int CODE_W  = 6;
    localparam int LINE_W  = 3;
    localparam int SUB_W   = CODE_W + LINE_W;
    localparam int HIGH_W  = ADDR_W - SUB_W;
    localparam int INV_BIT = 7;
    localparam int NUM_WIN = 2;

    localparam logic [ADDR_W-1:0] BOARD_BASE  = 16'h8400;
    localparam logic [ADDR_W-1:0] ATTR_BASE   = 16'hC000;
    localparam logic [ADDR_W-1:0] WIDE_MASK   = 16'hE100;
    localparam logic [ADDR_W-1:0] WIDE_MATCH  = 16'h2100;
    localparam logic [ADDR_W-1:0] RAW_LIMIT   = 16'h8000;
    localparam logic [ADDR_W-1:0] HALF_OFFSET = 16'h0200;

    localparam logic [DATA_W-1:0] ATTR_PLAIN = 8'h70;
    localparam logic [DATA_W-1:0] ATTR_DARK  = 8'h00;
    localparam logic [DATA_W-1:0] PIX_DARK   = 8'h00;

    typedef enum logic [1:0] {
        FM_PLAIN = 2'd0,
        FM_WIDE  = 2'd1,
        FM_BOARD = 2'd2,
        FM_RAW   = 2'd3
    } fetch_mode_e;

    // Add-on RAM window bounds, indexed by window number.
    function automatic logic [ADDR_W-1:0] win_lo(input int idx);
        return (idx == 0) ? 16'h2000 : 16'h4000;
    endfunction

    function automatic logic [ADDR_W-1:0] win_hi(input int idx);
        return (idx == 0) ? 16'h3FFF : 16'h7FFF;
    endfunction

    typedef struct packed {
        logic [ADDR_W-1:0] pat_addr;
        logic [ADDR_W-1:0] attr_addr;
        fetch_mode_e       mode;
        logic              pat_req;
        logic              attr_req;
        logic              inv;
        logic              dark;
        logic              colour;
    } fetch_rec_t;
endpackage

// File: rtl/patfetch_region.sv
// Decides whether a refresh address falls inside fitted add-on RAM.
// Assumes windows do not overlap; one enable bit per window.
module patfetch_region
    import patfetch_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_WIN-1:0] win_en,
    output logic               hit
);
    logic [NUM_WIN-1:0] win_hit;

    // One comparator pair per window.
    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
        assign win_hit[gi] = win_en[gi]
                           && (addr >= win_lo(gi))
                           && (addr <= win_hi(gi));
    end

    // Any window hit counts, and only below the raw limit.
    always_comb begin
        hit = (|win_hit) && (addr < RAW_LIMIT);
    end
endmodule

// File: rtl/patfetch_addr.sv
// Forms pattern and attribute addresses and registers them at the refresh strobe.
// Assumes the fetch inputs are stable in the strobe cycle.
module patfetch_addr
    import patfetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_strobe,
    input  logic [DATA_W-1:0] opcode,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [ADDR_W-1:0] ir_val,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic              sw_ram2000,
    input  logic              raw_hit,
    input  logic              sw_raw,
    input  logic              sw_board,
    input  logic              colour_en,
    input  logic              colour_mode,
    input  logic              sync_active,
    output fetch_rec_t        rec_q
);
    logic [SUB_W-1:0]  sub;
    logic              inv;
    logic              wide_ok;
    logic [ADDR_W-1:0] plain_addr;
    fetch_rec_t        rec_d;

    // Pattern sub-address and the 128-character condition.
    always_comb begin
        sub        = {opcode[CODE_W-1:0], line_cnt};
        inv        = opcode[INV_BIT];
        plain_addr = {ir_val[ADDR_W-1 -: HIGH_W], sub};
        wide_ok    = !sw_raw && sw_ram2000 && ((ir_val & WIDE_MASK) == WIDE_MATCH);
    end

    // Mode priority: board, then raw on a window hit, then wide, then plain.
    always_comb begin
        rec_d          = '0;
        rec_d.inv      = inv;
        rec_d.dark     = sync_active;
        rec_d.colour   = colour_en;
        rec_d.pat_req  = !sync_active;
        rec_d.attr_req = colour_en && !sync_active;
        if (sw_board) begin
            rec_d.mode     = FM_BOARD;
            rec_d.pat_addr = BOARD_BASE + ADDR_W'(sub) + (inv ? HALF_OFFSET : '0);
        end else if (sw_raw && raw_hit) begin
            rec_d.mode     = FM_RAW;
            rec_d.pat_addr = ir_val;
        end else if (wide_ok) begin
            rec_d.mode     = FM_WIDE;
            rec_d.pat_addr = plain_addr + (inv ? HALF_OFFSET : '0);
        end else begin
            rec_d.mode     = FM_PLAIN;
            rec_d.pat_addr = plain_addr;
        end
        if (colour_mode) begin
            rec_d.attr_addr = fetch_pc | ATTR_BASE;
        end else if (rec_d.mode == FM_RAW) begin
            rec_d.attr_addr = ATTR_BASE;
        end else begin
            rec_d.attr_addr = ATTR_BASE + ADDR_W'(sub);
        end
    end

    // Capture the fetch record on the refresh strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else if (fetch_strobe) begin
            rec_q <= rec_d;
        end
    end

    a_r10_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_strobe |=> $stable(rec_q.pat_addr) && $stable(rec_q.attr_addr));

    a_r9_no_req_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_strobe && sync_active) |=> (!rec_q.pat_req && !rec_q.attr_req));

    a_r4_board_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_q.mode == FM_BOARD) |-> (rec_q.pat_addr >= BOARD_BASE
                                     && rec_q.pat_addr < BOARD_BASE + 16'h0400));

    a_r5_raw_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_q.mode == FM_RAW) |-> (rec_q.pat_addr < RAW_LIMIT));
endmodule

// File: rtl/patfetch_out.sv
// Applies inversion, sync blanking and colour policy to returned read data.
// Assumes the fetch record is held until the read data arrives.
module patfetch_out
    import patfetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] pat_data,
    input  logic [DATA_W-1:0] attr_data,
    input  logic              inv,
    input  logic              dark,
    input  logic              colour,
    output logic [DATA_W-1:0] pix_out,
    output logic [DATA_W-1:0] attr_out,
    output logic              out_valid
);
    logic [DATA_W-1:0] pix_d;
    logic [DATA_W-1:0] attr_d;

    // Select final pixel and attribute bytes.
    always_comb begin
        if (dark) begin
            pix_d  = PIX_DARK;
            attr_d = ATTR_DARK;
        end else begin
            pix_d  = inv ? ~pat_data : pat_data;
            attr_d = colour ? attr_data : ATTR_PLAIN;
        end
    end

    // Register the output one clock after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out   <= '0;
            attr_out  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= rd_valid;
            if (rd_valid) begin
                pix_out  <= pix_d;
                attr_out <= attr_d;
            end
        end
    end

    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> out_valid);

    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !out_valid);

    a_r9_dark_pixels: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && dark) |=> (pix_out == PIX_DARK && attr_out == ATTR_DARK));

    a_r8_plain_attr: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !dark && !colour) |=> (attr_out == ATTR_PLAIN));
endmodule

// File: rtl/patfetch_gen.sv
// Top of the character pattern fetch address generator.
// Assumes the memory returns both bytes together, flagged by rd_valid.
module patfetch_gen
    import patfetch_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fetch_strobe,
    input  logic [7:0]  opcode,
    input  logic [15:0] fetch_pc,
    input  logic [15:0] ir_val,
    input  logic [2:0]  line_cnt,
    input  logic        sw_ram2000,
    input  logic        sw_ram4000,
    input  logic        sw_raw,
    input  logic        sw_board,
    input  logic        colour_en,
    input  logic        colour_mode,
    input  logic        sync_active,
    input  logic        rd_valid,
    input  logic [7:0]  pat_data,
    input  logic [7:0]  attr_data,
    output logic [15:0] pat_addr,
    output logic [15:0] attr_addr,
    output logic [1:0]  fetch_mode,
    output logic        pat_req,
    output logic        attr_req,
    output logic [7:0]  pix_out,
    output logic [7:0]  attr_out,
    output logic        out_valid
);
    logic       raw_hit;
    fetch_rec_t rec;

    patfetch_region u_region (
        .addr   (ir_val),
        .win_en ({sw_ram4000, sw_ram2000}),
        .hit    (raw_hit)
    );

    patfetch_addr u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_strobe (fetch_strobe),
        .opcode       (opcode),
        .fetch_pc     (fetch_pc),
        .ir_val       (ir_val),
        .line_cnt     (line_cnt),
        .sw_ram2000   (sw_ram2000),
        .raw_hit      (raw_hit),
        .sw_raw       (sw_raw),
        .sw_board     (sw_board),
        .colour_en    (colour_en),
        .colour_mode  (colour_mode),
        .sync_active  (sync_active),
        .rec_q        (rec)
    );

    patfetch_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_valid  (rd_valid),
        .pat_data  (pat_data),
        .attr_data (attr_data),
        .inv       (rec.inv),
        .dark      (rec.dark),
        .colour    (rec.colour),
        .pix_out   (pix_out),
        .attr_out  (attr_out),
        .out_valid (out_valid)
    );

    // Drive the registered record onto the ports.
    always_comb begin
        pat_addr   = rec.pat_addr;
        attr_addr  = rec.attr_addr;
        fetch_mode = rec.mode;
        pat_req    = rec.pat_req;
        attr_req   = rec.attr_req;
    end
endmodule

// File: tb/patfetch_gen_test.sv
module patfetch_gen_test;
    localparam int CLK_P = 10;

    logic clk = 0, rst_n = 0, fetch_strobe = 0;
    logic [7:0] opcode = 0;
    logic [15:0] fetch_pc = 0, ir_val = 0;
    logic [2:0] line_cnt = 0;
    logic sw_ram2000 = 0, sw_ram4000 = 0, sw_raw = 0, sw_board = 0;
    logic colour_en = 0, colour_mode = 0, sync_active = 0, rd_valid = 0;
    logic [7:0] pat_data = 0, attr_data = 0;
    logic [15:0] pat_addr, attr_addr;
    logic [1:0] fetch_mode;
    logic pat_req, attr_req, out_valid;
    logic [7:0] pix_out, attr_out;
    int checks = 0, fails = 0;
    logic done = 0;

    always #(CLK_P/2) clk = ~clk;

    patfetch_gen uut (.*);

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [1:0] e_mode();
        logic hit;
        hit = (sw_ram2000 && ir_val >= 16'h2000 && ir_val < 16'h4000)
           || (sw_ram4000 && ir_val >= 16'h4000 && ir_val < 16'h8000);
        if (sw_board) return 2;
        if (sw_raw && hit) return 3;
        if (!sw_raw && sw_ram2000 && ir_val[15:13] == 3'b001 && ir_val[8]) return 1;
        return 0;
    endfunction

    function automatic logic [15:0] e_pat(input logic [1:0] m);
        logic [15:0] s;
        s = {7'd0, opcode[5:0], line_cnt};
        case (m)
            2: return 16'h8400 + s + (opcode[7] ? 16'h200 : 16'h0);
            3: return ir_val;
            1: return {ir_val[15:9], 9'd0} + s + (opcode[7] ? 16'h200 : 16'h0);
            default: return {ir_val[15:9], 9'd0} + s;
        endcase
    endfunction

    function automatic logic [15:0] e_attr(input logic [1:0] m);
        if (colour_mode) return fetch_pc | 16'hC000;
        if (m == 3) return 16'hC000;
        return 16'hC000 + {7'd0, opcode[5:0], line_cnt};
    endfunction

    // One fetch followed through to its output.
    task automatic one_fetch();
        logic [1:0] m;
        logic [7:0] ep, ea;
        string tag;
        m = e_mode();
        tag = (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
        if (sw_raw && !sw_board && m == 0) tag = "R5";
        fetch_strobe = 1;
        @(posedge clk); #1;
        fetch_strobe = 0;
        chk({tag, " pat_addr"}, pat_addr, e_pat(m));
        chk({tag, " fetch_mode"}, {14'd0, fetch_mode}, {14'd0, m});
        chk("R7 attr_addr", attr_addr, e_attr(m));
        chk(sync_active ? "R9 pat_req" : "R8 pat_req", {15'd0, pat_req}, {15'd0, !sync_active});
        chk(sync_active ? "R9 attr_req" : "R8 attr_req", {15'd0, attr_req},
            {15'd0, colour_en && !sync_active});
        pat_data = 8'($urandom); attr_data = 8'($urandom);
        ep = sync_active ? 8'h00 : (opcode[7] ? ~pat_data : pat_data);
        ea = sync_active ? 8'h00 : (colour_en ? attr_data : 8'h70);
        // Changing inputs without a strobe must not move the addresses (R10).
        ir_val = ~ir_val; opcode = ~opcode; sw_board = ~sw_board;
        rd_valid = 1;
        @(posedge clk); #1;
        rd_valid = 0;
        chk(sync_active ? "R9 pix_out" : "R6 pix_out", {8'd0, pix_out}, {8'd0, ep});
        chk(sync_active ? "R9 attr_out" : "R8 attr_out", {8'd0, attr_out}, {8'd0, ea});
        chk("R6 out_valid high", {15'd0, out_valid}, 16'd1);
        chk("R10 pat_addr hold", pat_addr, e_pat_hold);
        @(posedge clk); #1;
        chk("R6 out_valid pulse", {15'd0, out_valid}, 16'd0);
    endtask

    logic [15:0] e_pat_hold;

    task automatic setup(input logic [7:0] op, input logic [15:0] ir, input logic [2:0] ln,
                         input logic r2, input logic r4, input logic rw, input logic bd,
                         input logic ce, input logic cm, input logic sy);
        opcode = op; ir_val = ir; line_cnt = ln; fetch_pc = 16'(($urandom));
        sw_ram2000 = r2; sw_ram4000 = r4; sw_raw = rw; sw_board = bd;
        colour_en = ce; colour_mode = cm; sync_active = sy;
        e_pat_hold = e_pat(e_mode());
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pat_addr", pat_addr, 0);
        chk("R1 attr_addr", attr_addr, 0);
        chk("R1 mode", {14'd0, fetch_mode}, 0);
        chk("R1 reqs", {14'd0, pat_req, attr_req}, 0);
        chk("R1 pix_out", {8'd0, pix_out}, 0);
        chk("R1 attr_out", {8'd0, attr_out}, 0);
        chk("R1 out_valid", {15'd0, out_valid}, 0);
        rst_n = 1;
        // Directed corners.
        setup(8'h80, 16'h2100, 3'd0, 1, 0, 0, 0, 0, 0, 0); one_fetch(); // R3 inverse half
        chk("R3 corner addr", e_pat_hold, 16'h2200);
        setup(8'h80, 16'h2100, 3'd0, 0, 0, 0, 0, 0, 0, 0); one_fetch(); // R2 without 8K RAM
        setup(8'hBF, 16'h2100, 3'd7, 1, 1, 1, 1, 1, 0, 0); one_fetch(); // R4 top of board
        chk("R4 corner addr", e_pat_hold, 16'h87FF);
        setup(8'h05, 16'h8000, 3'd2, 1, 1, 1, 0, 1, 1, 0); one_fetch(); // R5 at limit
        setup(8'h05, 16'h7FFF, 3'd2, 0, 1, 1, 0, 1, 0, 0); one_fetch(); // R5 raw hit
        setup(8'h05, 16'h2100, 3'd2, 1, 0, 1, 0, 0, 0, 0); one_fetch(); // R5 raw blocks R3 wide
        setup(8'h85, 16'h3F00, 3'd2, 0, 0, 1, 0, 0, 0, 0); one_fetch(); // R5 raw miss
        setup(8'hC1, 16'h2100, 3'd4, 1, 0, 0, 0, 1, 0, 1); one_fetch(); // R9 sync
        setup(8'h41, 16'h1F00, 3'd4, 1, 1, 0, 0, 1, 1, 0); one_fetch(); // R2 bit 8 ignored
        // Random fetches.
        for (int i = 0; i < 400; i++) begin
            logic [15:0] ir;
            ir = 16'($urandom);
            if (i % 3 == 0) begin ir[15:13] = 3'b001; ir[8] = 1'b1; end
            if (i % 5 == 1) ir[15] = 1'b0;
            setup(8'($urandom), ir, 3'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), ($urandom % 4) == 0, 1'($urandom), 1'($urandom),
                  ($urandom % 6) == 0);
            one_fetch();
        end
        done = 1;
    end

    initial begin
        fork
            wait (done == 1);
            begin
                repeat (150000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule